// File: doc/BRIEF.md
# FIFO with Column-Parity Fault Detector

A single-clock first-in first-out buffer that watches its own storage for corruption at very low cost. One register, as wide as a data word, tracks the XOR of every word that enters the storage array and every word that leaves it. The register is not a per-entry check code. It is a running column parity over the whole write stream and the whole read stream.

Whenever the buffer is empty, everything that went in has also come out. If no stored bit changed in between, the running parity is therefore zero. A non-zero value while empty means that some column saw an odd number of bit flips, and the block raises a sticky fault output. Detection is deferred until the buffer drains, and flips that cancel inside one column go unseen. A test-only port can flip chosen bits of a stored slot so that the checker can be exercised.

Top module: `fifo_cp_top`

## Requirements
- R1: After reset, `empty_o` is 1, `full_o` is 0 and `fault_o` is 0. Reset also zeroes both pointers and the parity register.
- R2: Words leave in the order they were accepted. `dout_o` always shows the oldest stored word, exactly as it now sits in storage.
- R3: `full_o` rises once DEPTH words are held. A push while full is ignored: nothing is stored and the parity register is untouched, so a later drain returns only the original words and reports no fault.
- R4: A pop while empty is ignored. `empty_o` stays 1, the read position does not move, and no fault follows.
- R5: With no corruption, any mix of pushes, pops and same-cycle push-with-pop leaves the parity register at zero when the buffer drains, and `fault_o` stays 0.
- R6: `fault_o` is never set while the buffer holds data. If an odd number of bits in one column was flipped, `fault_o` rises at the first clock edge after the edge that made the buffer empty.
- R7: Two flips in the same bit column, in different slots, cancel and are not flagged.
- R8: `fault_o` is sticky until `fault_clr_i` is sampled high. That edge zeroes both `fault_o` and the parity register.
- R9: While `inj_en_i` is high, the stored slot `inj_idx_i` is XORed with `inj_mask_i` at the clock edge. After reset, the n-th word pushed occupies slot n mod DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_i | input | 1 | Write request |
| din_i | input | WIDTH | Word to write |
| full_o | output | 1 | Buffer holds DEPTH words |
| pop_i | input | 1 | Read request |
| dout_o | output | WIDTH | Oldest stored word |
| empty_o | output | 1 | Buffer holds no word |
| fault_o | output | 1 | Sticky corruption flag |
| fault_clr_i | input | 1 | Clears the flag and the parity register |
| inj_en_i | input | 1 | Test-only fault injection strobe |
| inj_idx_i | input | $clog2(DEPTH) | Slot to corrupt |
| inj_mask_i | input | WIDTH | Bits to flip in that slot |

## Verification
The assertions take for granted that `fault_clr_i` is raised only while the buffer is empty, since clearing the parity register while words are still held would corrupt the running parity. The bench asserts the clear only after a full drain. It injects faults only while the buffer holds data and keeps the injection strobe low in every cycle that pushes into the same slot. Every scenario starts from reset, so each injected pattern begins from a zero parity register.

// File: rtl/fifo_cp_pkg.sv
// Package: shared types for the column-parity FIFO.
// Assumes nothing beyond single-clock use.
package fifo_cp_pkg;

    // Accepted transfers for one cycle.
    typedef struct packed {
        logic push_ok;
        logic pop_ok;
    } fifo_cp_xfer_t;

endpackage

// File: rtl/fifo_cp_ptrs.sv
// Pointer and flag logic: read and write pointers with one extra wrap bit.
// Decides which requests are accepted and derives full and empty from the pointers.
// Assumes DEPTH is a power of two, at least 2.
module fifo_cp_ptrs
    import fifo_cp_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic          pop_i,
    output fifo_cp_xfer_t xfer_o,
    output logic [AW-1:0] wr_idx_o,
    output logic [AW-1:0] rd_idx_o,
    output logic          full_o,
    output logic          empty_o
);

    logic [AW:0] wr_ptr;
    logic [AW:0] rd_ptr;

    // Flags: equal pointers mean empty; equal indices with different wrap bits mean full.
    always_comb begin
        empty_o = (wr_ptr == rd_ptr);
        full_o  = (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]) && (wr_ptr[AW] != rd_ptr[AW]);
    end

    // Acceptance: drop a push while full and a pop while empty.
    always_comb begin
        xfer_o.push_ok = push_i && !full_o;
        xfer_o.pop_ok  = pop_i && !empty_o;
    end

    assign wr_idx_o = wr_ptr[AW-1:0];
    assign rd_idx_o = rd_ptr[AW-1:0];

    // Pointer update on accepted transfers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (xfer_o.push_ok) wr_ptr <= wr_ptr + 1'b1;
            if (xfer_o.pop_ok)  rd_ptr <= rd_ptr + 1'b1;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        full_o && push_i |=> $stable(wr_ptr) || $past(pop_i)); // R3
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(full_o && empty_o)); // R3
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        empty_o |=> $stable(rd_ptr)); // R4

endmodule

// File: rtl/fifo_cp_store.sv
// Storage array: DEPTH slots of WIDTH bits, one register per slot.
// Writes the accepted word and applies the test-only XOR injection.
// Offers an asynchronous read of the addressed slot.
// Assumes the injection is not aimed at the slot being written in the same cycle.
module fifo_cp_store #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 32,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en_i,
    input  logic [AW-1:0]    wr_idx_i,
    input  logic [WIDTH-1:0] wr_data_i,
    input  logic [AW-1:0]    rd_idx_i,
    output logic [WIDTH-1:0] rd_data_o,
    input  logic             inj_en_i,
    input  logic [AW-1:0]    inj_idx_i,
    input  logic [WIDTH-1:0] inj_mask_i
);

    logic [WIDTH-1:0] slots [DEPTH];

    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        logic [WIDTH-1:0] slot_q;
        logic             hit_wr;
        logic             hit_inj;

        // Slot select decode.
        always_comb begin
            hit_wr  = wr_en_i && (wr_idx_i == AW'(s));
            hit_inj = inj_en_i && (inj_idx_i == AW'(s));
        end

        // Slot update: a write loads the new word, an injection flips the masked bits.
        always_ff @(posedge clk) begin
            if (hit_wr)       slot_q <= wr_data_i;
            else if (hit_inj) slot_q <= slot_q ^ inj_mask_i;
        end

        assign slots[s] = slot_q;
    end

    assign rd_data_o = slots[rd_idx_i];

endmodule

// File: rtl/fifo_cp_parity.sv
// Column-parity checker: one WIDTH-bit register XORed with every accepted
// written word and every accepted read word. A non-zero value while the
// buffer is empty sets a sticky fault one edge later.
// Assumes the clear is raised only while the buffer is empty.
module fifo_cp_parity #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [WIDTH-1:0] wr_data_i,
    input  logic             rd_en_i,
    input  logic [WIDTH-1:0] rd_data_i,
    input  logic             empty_i,
    input  logic             clr_i,
    output logic             fault_o
);

    logic [WIDTH-1:0] acc_q;
    logic [WIDTH-1:0] delta;

    // Combined update for this cycle; a same-cycle write and read fold into one term.
    always_comb begin
        delta = (wr_en_i ? wr_data_i : '0) ^ (rd_en_i ? rd_data_i : '0);
    end

    // Running parity register; a clear restarts it from zero.
    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= (clr_i ? '0 : acc_q) ^ delta;
    end

    // Sticky fault, checked against the registered empty state and parity.
    always_ff @(posedge clk) begin
        if (!rst_n)     fault_o <= 1'b0;
        else if (clr_i) fault_o <= 1'b0;
        else if (empty_i && (acc_q != '0)) fault_o <= 1'b1;
    end

    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o && !clr_i |=> fault_o); // R8
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !fault_o); // R8
    AST_CLEAR_ONLY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |-> empty_i); // R8
    AST_QUIET_WHILE_HOLDING: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_o && !empty_i |=> !fault_o); // R6

endmodule

// File: rtl/fifo_cp_top.sv
// Top: synchronous FIFO with a shared column-parity fault detector.
// Connects the pointer logic, the storage array and the parity checker.
// Assumes DEPTH is a power of two (>= 2) and a single clock domain.
module fifo_cp_top
    import fifo_cp_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int WIDTH = 32,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [WIDTH-1:0] din_i,
    output logic             full_o,
    input  logic             pop_i,
    output logic [WIDTH-1:0] dout_o,
    output logic             empty_o,
    output logic             fault_o,
    input  logic             fault_clr_i,
    input  logic             inj_en_i,
    input  logic [AW-1:0]    inj_idx_i,
    input  logic [WIDTH-1:0] inj_mask_i
);

    fifo_cp_xfer_t xfer;
    logic [AW-1:0] wr_idx;
    logic [AW-1:0] rd_idx;

    fifo_cp_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_i   (push_i),
        .pop_i    (pop_i),
        .xfer_o   (xfer),
        .wr_idx_o (wr_idx),
        .rd_idx_o (rd_idx),
        .full_o   (full_o),
        .empty_o  (empty_o)
    );

    fifo_cp_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk        (clk),
        .wr_en_i    (xfer.push_ok),
        .wr_idx_i   (wr_idx),
        .wr_data_i  (din_i),
        .rd_idx_i   (rd_idx),
        .rd_data_o  (dout_o),
        .inj_en_i   (inj_en_i),
        .inj_idx_i  (inj_idx_i),
        .inj_mask_i (inj_mask_i)
    );

    fifo_cp_parity #(.WIDTH(WIDTH)) u_parity (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (xfer.push_ok),
        .wr_data_i (din_i),
        .rd_en_i   (xfer.pop_ok),
        .rd_data_i (dout_o),
        .empty_i   (empty_o),
        .clr_i     (fault_clr_i),
        .fault_o   (fault_o)
    );

endmodule

// File: tb/tb_fifo_cp_top.sv
// Bench: near-exhaustive sweeps on a small configuration (4 slots x 8 bits).
module tb_fifo_cp_top;
    localparam int D  = 4;
    localparam int W  = 8;
    localparam int AW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          push_i = 1'b0;
    logic [W-1:0]  din_i = '0;
    logic          full_o;
    logic          pop_i = 1'b0;
    logic [W-1:0]  dout_o;
    logic          empty_o;
    logic          fault_o;
    logic          fault_clr_i = 1'b0;
    logic          inj_en_i = 1'b0;
    logic [AW-1:0] inj_idx_i = '0;
    logic [W-1:0]  inj_mask_i = '0;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    fifo_cp_top #(.DEPTH(D), .WIDTH(W)) dut (
        .clk(clk), .rst_n(rst_n), .push_i(push_i), .din_i(din_i), .full_o(full_o),
        .pop_i(pop_i), .dout_o(dout_o), .empty_o(empty_o), .fault_o(fault_o),
        .fault_clr_i(fault_clr_i), .inj_en_i(inj_en_i), .inj_idx_i(inj_idx_i),
        .inj_mask_i(inj_mask_i)
    );

    function automatic logic [W-1:0] word(input int k);
        return W'(k * 53 + 17);
    endfunction

    task automatic check(input logic ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic push(input logic [W-1:0] v);
        push_i = 1'b1; din_i = v;
        @(negedge clk);
        push_i = 1'b0;
    endtask

    task automatic pop(output logic [W-1:0] v);
        v = dout_o; pop_i = 1'b1;
        @(negedge clk);
        pop_i = 1'b0;
    endtask

    task automatic inject(input int slot, input logic [W-1:0] m);
        inj_en_i = 1'b1; inj_idx_i = AW'(slot); inj_mask_i = m;
        @(negedge clk);
        inj_en_i = 1'b0; inj_mask_i = '0;
    endtask

    initial begin
        logic [W-1:0] v;
        @(negedge clk);
        do_reset();
        // R1 reset state
        check(empty_o == 1'b1, "R1", 32'(empty_o), 1);
        check(full_o == 1'b0, "R1", 32'(full_o), 0);
        check(fault_o == 1'b0, "R1", 32'(fault_o), 0);

        // R2 R3 R5 fill-level sweep with clean traffic
        for (int n = 1; n <= D; n++) begin
            do_reset();
            for (int k = 0; k < n; k++) push(word(k + n));
            check(full_o == (n == D), "R3", 32'(full_o), 32'(n == D));
            for (int k = 0; k < n; k++) begin
                pop(v);
                check(v == word(k + n), "R2", 32'(v), 32'(word(k + n)));
            end
            @(negedge clk);
            check(fault_o == 1'b0, "R5", 32'(fault_o), 0);
        end

        // R3 push while full is ignored
        do_reset();
        for (int k = 0; k < D; k++) push(word(k));
        push(8'hA5);
        check(full_o == 1'b1, "R3", 32'(full_o), 1);
        for (int k = 0; k < D; k++) begin
            pop(v);
            check(v == word(k), "R3", 32'(v), 32'(word(k)));
        end
        check(empty_o == 1'b1, "R3", 32'(empty_o), 1);
        @(negedge clk);
        check(fault_o == 1'b0, "R3", 32'(fault_o), 0);

        // R4 pop while empty is ignored
        do_reset();
        for (int k = 0; k < 3; k++) pop(v);
        check(empty_o == 1'b1, "R4", 32'(empty_o), 1);
        check(fault_o == 1'b0, "R4", 32'(fault_o), 0);
        push(8'h3C);
        check(dout_o == 8'h3C, "R4", 32'(dout_o), 32'h3C);
        pop(v);
        @(negedge clk);
        check(fault_o == 1'b0, "R4", 32'(fault_o), 0);

        // R5 simultaneous push and pop
        do_reset();
        push(word(0));
        push(word(1));
        for (int k = 0; k < 10; k++) begin
            v = dout_o;
            push_i = 1'b1; pop_i = 1'b1; din_i = word(k + 2);
            @(negedge clk);
            push_i = 1'b0; pop_i = 1'b0;
            check(v == word(k), "R5", 32'(v), 32'(word(k)));
        end
        for (int k = 10; k < 12; k++) begin
            pop(v);
            check(v == word(k), "R5", 32'(v), 32'(word(k)));
        end
        @(negedge clk);
        check(fault_o == 1'b0, "R5", 32'(fault_o), 0);

        // R6 R9 single-bit flip sweep over every slot and bit
        for (int s = 0; s < D; s++) begin
            for (int b = 0; b < W; b++) begin
                do_reset();
                for (int k = 0; k < D; k++) push(word(k + s));
                inject(s, W'(1) << b);
                check(fault_o == 1'b0, "R6", 32'(fault_o), 0);
                for (int k = 0; k < D; k++) begin
                    logic [W-1:0] e;
                    e = word(k + s) ^ ((k == s) ? (W'(1) << b) : '0);
                    pop(v);
                    check(v == e, "R9", 32'(v), 32'(e));
                end
                check(fault_o == 1'b0, "R6", 32'(fault_o), 0);
                @(negedge clk);
                check(fault_o == 1'b1, "R6", 32'(fault_o), 1);
            end
        end

        // R7 paired flips in one column cancel
        for (int b = 0; b < W; b++) begin
            do_reset();
            for (int k = 0; k < D; k++) push(word(k));
            inject(0, W'(1) << b);
            inject(D - 1, W'(1) << b);
            for (int k = 0; k < D; k++) pop(v);
            @(negedge clk);
            @(negedge clk);
            check(fault_o == 1'b0, "R7", 32'(fault_o), 0);
        end

        // R8 sticky fault, then clear
        do_reset();
        push(word(5));
        inject(0, 8'h10);
        pop(v);
        @(negedge clk);
        check(fault_o == 1'b1, "R8", 32'(fault_o), 1);
        for (int k = 0; k < 5; k++) @(negedge clk);
        check(fault_o == 1'b1, "R8", 32'(fault_o), 1);
        fault_clr_i = 1'b1;
        @(negedge clk);
        fault_clr_i = 1'b0;
        check(fault_o == 1'b0, "R8", 32'(fault_o), 0);
        for (int k = 0; k < 3; k++) @(negedge clk);
        check(fault_o == 1'b0, "R8", 32'(fault_o), 0);
        push(word(9));
        pop(v);
        @(negedge clk);
        check(fault_o == 1'b0, "R8", 32'(fault_o), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule